// File: doc/BRIEF.md
# Programmable SPI Master Frame Engine

This block is a synchronous serial master that sends and receives one SPI frame at a time. A parallel word is handed over through a ready/valid transmit port. The engine shifts that word out on `mosi` while it shifts `miso` in, and it presents the received word on `rx_data` with a one-cycle `rx_valid` strobe. The frame length, the idle clock level, the capture phase and the bit rate are all set by static configuration inputs. These inputs are sampled when a word is accepted and stay frozen until the frame ends.

The serial clock comes from a two-stage divider. The first stage is a prescaler that uses only even divisors. The second stage is a rate counter running from 0 to 255. A loopback switch routes the outgoing shift register straight into the receive shifter, so the datapath can be tested without an external device. Data words are right-justified on both sides, and bits are sent most significant first.

Top module: `spi_frame_master`

## Requirements
- R1: The half period of `sclk` is H = (P/2)·(scr+1) clock cycles. P is `prescale` with bit 0 forced to zero, and a result of 0 is used as 2. The first `sclk` transition comes H cycles after the edge that accepts a word. `cs_n` stays low for (2n+1)·H cycles, where n is the frame size.
- R2: For `size_code` values 3 to 15 the frame size is n = size_code+1 bits. Codes 0, 1 and 2 give 4-bit frames. Every frame has exactly 2n `sclk` transitions.
- R3: While no frame is in progress, `sclk` rests at the `cpol` level: 0 gives low, 1 gives high. Every frame ends with `sclk` back at the level it had when the frame started.
- R4: Bits go out MSB first. With `cpha`=0, data is captured on the 1st, 3rd, … transitions and `mosi` changes on the others. With `cpha`=1, data is captured on the 2nd, 4th, … transitions and the first transition comes before the first capture.
- R5: Only bits n-1..0 of `tx_data` are sent. The bits above them have no effect on `mosi`.
- R6: `rx_valid` is high for exactly one cycle per frame, in the cycle after the last capture transition. `rx_data` then holds the n received bits right-justified, with zeros above them.
- R7: With `loopback`=1 the receive shifter takes the transmit shifter output, and `miso` is ignored.
- R8: `tx_ready` = `enable` and no frame in progress. A word is accepted only when `tx_valid` and `tx_ready` are both high. While `enable` is low, `tx_valid` starts nothing.
- R9: Changes to `cpol`, `cpha`, `size_code`, `scr`, `prescale` or `loopback` during a frame do not affect that frame.
- R10: After reset `cs_n` is high, `rx_valid` is low and `mosi` is low. `cs_n` is low only for the length of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: capture on leading transitions, 1: capture on trailing transitions |
| size_code | input | 4 | Frame size minus one (0..2 treated as 3) |
| scr | input | 8 | Second divider stage, divides by scr+1 |
| prescale | input | 8 | Even prescale divisor, bit 0 ignored |
| loopback | input | 1 | Routes the transmit shifter into the receive shifter |
| tx_data | input | 16 | Right-justified word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Engine is idle and enabled |
| rx_data | output | 16 | Right-justified received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low frame select |

## Verification
Every timed result depends on H. The first `sclk` transition is due H cycles after the accepting edge, and `rx_valid` rises in the cycle after the edge that performs the last capture. `cs_n` rises (2n+1)·H cycles after acceptance. The bench samples all outputs on falling clock edges. It counts the low cycles of `cs_n` and the cycles before the first transition, and compares these with H computed from its own copy of the configuration. Word contents and the strobe count are compared only after `cs_n` has returned high, so the checks never depend on the exact cycle of an individual transition.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DW   = 16,
  parameter int SCRW = 8,
  parameter int PSW  = 8,
  localparam int SW  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [SW-1:0]   size_code,
  input  logic [SCRW-1:0] scr,
  input  logic [PSW-1:0]  prescale,
  input  logic            loopback,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n
);
  localparam int EW = $clog2(2*DW+1);
  localparam int HW = PSW-1;

  logic            busy_q, cs_q, sclk_q, cpha_q, lb_q, rx_valid_q;
  logic [SW-1:0]   nm1_q;
  logic [SCRW-1:0] scr_q, scr_cnt;
  logic [HW-1:0]   half_q, pre_cnt;
  logic [EW-1:0]   ecnt;
  logic [DW-1:0]   tx_sh, rx_data_q;
  logic [DW-2:0]   rx_sh;

  wire [SW-1:0] nm1_in   = (size_code < SW'(3)) ? SW'(3) : size_code;
  wire [HW-1:0] ps_half  = HW'(prescale >> 1);
  wire [HW-1:0] half_in  = (ps_half == '0) ? '0 : ps_half - HW'(1);
  wire [EW-1:0] twon     = EW'({nm1_q, 1'b0}) + EW'(2);
  wire          accept   = tx_valid & enable & ~busy_q;
  wire          pre_wrap = (pre_cnt == half_q);
  wire          tick     = busy_q & pre_wrap & (scr_cnt == scr_q);
  wire          cap      = cpha_q ? ecnt[0] : ~ecnt[0];
  wire          at_end   = (ecnt == twon);
  wire          last_cap = cap & (ecnt == twon - (cpha_q ? EW'(1) : EW'(2)));
  wire          launch   = ~cap & ~(cpha_q & (ecnt == '0));
  wire          in_bit   = lb_q ? tx_sh[DW-1] : miso;
  wire [DW-1:0] rx_next  = {rx_sh, in_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cs_q       <= 1'b1;
      sclk_q     <= 1'b0;
      cpha_q     <= 1'b0;
      lb_q       <= 1'b0;
      rx_valid_q <= 1'b0;
      nm1_q      <= '0;
      scr_q      <= '0;
      scr_cnt    <= '0;
      half_q     <= '0;
      pre_cnt    <= '0;
      ecnt       <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cs_q    <= 1'b0;
        sclk_q  <= cpol;
        cpha_q  <= cpha;
        lb_q    <= loopback;
        nm1_q   <= nm1_in;
        scr_q   <= scr;
        half_q  <= half_in;
        pre_cnt <= '0;
        scr_cnt <= '0;
        ecnt    <= '0;
        tx_sh   <= tx_data << (SW'(DW-1) - nm1_in);
        rx_sh   <= '0;
      end else if (busy_q) begin
        pre_cnt <= pre_wrap ? '0 : pre_cnt + HW'(1);
        if (pre_wrap) scr_cnt <= (scr_cnt == scr_q) ? '0 : scr_cnt + SCRW'(1);
        if (tick) begin
          if (at_end) begin
            busy_q <= 1'b0;
            cs_q   <= 1'b1;
          end else begin
            sclk_q <= ~sclk_q;
            ecnt   <= ecnt + EW'(1);
            if (cap) rx_sh <= rx_next[DW-2:0];
            if (last_cap) begin
              rx_data_q  <= rx_next;
              rx_valid_q <= 1'b1;
            end
            if (launch) tx_sh <= {tx_sh[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign tx_ready = enable & ~busy_q;
  assign sclk     = busy_q ? sclk_q : cpol;
  assign mosi     = busy_q & tx_sh[DW-1];
  assign cs_n     = cs_q;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
endmodule

module spi_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic sclk,
  input logic cs_n
);
  logic sclk_start;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_start <= 1'b0;
    else if (tx_valid && tx_ready) sclk_start <= cpol;

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r6_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!cs_n && !tx_ready));
  a_r10_no_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !tx_ready);
  a_r3_end_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) == sclk_start));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cpol)) |-> $stable(sclk));
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic enable, cpol, cpha, loopback, tx_valid, miso;
  logic [3:0] size_code;
  logic [7:0] scr, prescale;
  logic [15:0] tx_data;
  wire tx_ready, rx_valid, sclk, mosi, cs_n;
  wire [15:0] rx_data;

  spi_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .size_code(size_code), .scr(scr), .prescale(prescale), .loopback(loopback),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int checks = 0, errors = 0;
  int exp_n = 4, exp_h = 1;
  bit exp_cpha = 0, exp_lb = 0;
  logic [15:0] slave_word = 16'h0;

  bit prev_cs = 1'b1, prev_sclk = 1'b0, done = 1'b0;
  int eidx = 0, cs_len = 0, first_delay = 0, rxv_count = 0;
  logic [15:0] mbits = 16'h0, slave_sh = 16'h0, rx_got = 16'h0;

  function automatic int fn_n(input logic [3:0] code);
    return (code < 4'd3) ? 4 : int'(code) + 1;
  endfunction

  function automatic int fn_h(input logic [7:0] ps, input logic [7:0] s);
    int p = int'(ps) & 32'hFE;
    if (p == 0) p = 2;
    return (p / 2) * (int'(s) + 1);
  endfunction

  function automatic logic [15:0] fn_mask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // slave model and line monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rxv_count++;
        rx_got = rx_data;
      end
      if (prev_cs && !cs_n) begin
        eidx = 0; mbits = 16'h0; cs_len = 0; first_delay = -1;
        slave_sh = slave_word;
        miso = slave_sh[exp_n-1];
        prev_sclk = sclk;
      end else if (!cs_n && sclk != prev_sclk) begin
        if (eidx == 0) first_delay = cs_len;
        if (((eidx % 2) == 0) == !exp_cpha) mbits = {mbits[14:0], mosi};
        else if (!(exp_cpha && eidx == 0)) begin
          slave_sh = slave_sh << 1;
          miso = slave_sh[exp_n-1];
        end
        eidx++;
      end
      if (!cs_n) cs_len++;
      if (!prev_cs && cs_n) done = 1'b1;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic run_frame(input logic [15:0] w, input logic [15:0] sw, input bit perturb);
    logic [15:0] m, exp_rx;
    bit s_cpol, s_cpha, s_lb;
    logic [3:0] s_code;
    logic [7:0] s_scr, s_ps;
    exp_n = fn_n(size_code); exp_h = fn_h(prescale, scr);
    exp_cpha = cpha; exp_lb = loopback; slave_word = sw;
    s_cpol = cpol; s_cpha = cpha; s_lb = loopback; s_code = size_code; s_scr = scr; s_ps = prescale;
    done = 1'b0; rxv_count = 0;
    while (!tx_ready) @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0; tx_data = 16'($urandom);
    chk(!tx_ready, "R8 ready low in frame", int'(tx_ready), 0);
    if (perturb) begin
      @(negedge clk);
      cpol = ~cpol; cpha = ~cpha; size_code = ~size_code;
      scr = scr + 8'd3; prescale = prescale + 8'd6; loopback = ~loopback;
    end
    while (!done) @(negedge clk);
    cpol = s_cpol; cpha = s_cpha; loopback = s_lb; size_code = s_code; scr = s_scr; prescale = s_ps;
    @(negedge clk);
    m = fn_mask(exp_n);
    exp_rx = exp_lb ? (w & m) : (sw & m);
    chk(mbits == (w & m), perturb ? "R9 R4 R5 mosi bits" : "R4 R5 mosi bits", int'(mbits), int'(w & m));
    chk(rx_got == exp_rx, perturb ? "R9 R6 R7 rx word" : "R6 R7 rx word", int'(rx_got), int'(exp_rx));
    chk(rxv_count == 1, "R6 strobe count", rxv_count, 1);
    chk(eidx == 2 * exp_n, perturb ? "R9 R2 edge count" : "R2 edge count", eidx, 2 * exp_n);
    chk(first_delay == exp_h, "R1 first edge delay", first_delay, exp_h);
    chk(cs_len == (2 * exp_n + 1) * exp_h, "R1 select length", cs_len, (2 * exp_n + 1) * exp_h);
    chk(sclk == cpol && cs_n, "R3 idle level", int'(sclk), int'(cpol));
  endtask

  task automatic cfg(input bit pol, input bit pha, input logic [3:0] code,
                     input logic [7:0] s, input logic [7:0] ps, input bit lb);
    cpol = pol; cpha = pha; size_code = code; scr = s; prescale = ps; loopback = lb;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    enable = 1'b0; cpol = 1'b0; cpha = 1'b0; loopback = 1'b0; tx_valid = 1'b0; miso = 1'b0;
    size_code = 4'hF; scr = 8'd0; prescale = 8'd2; tx_data = 16'h0;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R10 reset cs_n", int'(cs_n), 1);
    chk(rx_valid == 1'b0, "R10 reset rx_valid", int'(rx_valid), 0);
    chk(mosi == 1'b0, "R10 reset mosi", int'(mosi), 0);
    chk(sclk == 1'b0, "R3 reset sclk low", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R3 idle high", int'(sclk), 1);
    cpol = 1'b0;
    chk(tx_ready == 1'b0, "R8 ready low when disabled", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 16'hFFFF;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!cs_n) chk(1'b0, "R8 start while disabled", int'(cs_n), 1);
    end
    tx_valid = 1'b0;
    chk(cs_n == 1'b1, "R8 no frame while disabled", int'(cs_n), 1);
    enable = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R8 ready when idle", int'(tx_ready), 1);

    cfg(0, 0, 4'hF, 8'd0, 8'd2, 0); run_frame(16'hA5C3, 16'h3C5A, 0);
    cfg(1, 1, 4'hF, 8'd0, 8'd2, 0); run_frame(16'h8001, 16'h7FFE, 0);
    cfg(0, 1, 4'h7, 8'd1, 8'd7, 0); run_frame(16'hFF96, 16'hAB69, 0);
    cfg(1, 0, 4'h7, 8'd2, 8'd4, 0); run_frame(16'h1234, 16'h00C3, 0);
    cfg(0, 0, 4'h1, 8'd0, 8'd0, 0); run_frame(16'hFFFA, 16'h0009, 0);
    cfg(1, 1, 4'h0, 8'd1, 8'd3, 0); run_frame(16'h0005, 16'hFFF6, 0);
    cfg(0, 1, 4'hB, 8'd0, 8'd2, 1); run_frame(16'h1234, 16'hFFFF, 0);
    cfg(1, 0, 4'hF, 8'd1, 8'd2, 1); run_frame(16'hC0DE, 16'h0000, 0);
    cfg(0, 0, 4'h3, 8'd255, 8'd2, 0); run_frame(16'h000A, 16'h0005, 0);
    cfg(1, 0, 4'h3, 8'd0, 8'd254, 0); run_frame(16'h0003, 16'h000C, 0);
    cfg(0, 0, 4'h9, 8'd1, 8'd4, 0); run_frame(16'h02AB, 16'h0154, 1);
    cfg(1, 1, 4'h5, 8'd0, 8'd2, 1); run_frame(16'h0033, 16'h000F, 1);

    for (int k = 0; k < 40; k++) begin
      cfg(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom_range(0, 3)),
          8'($urandom_range(0, 9)), 1'($urandom));
      run_frame(16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule